// File: doc/BRIEF.md
# Operand Bypass and Load-Hazard Interlock

This block is the combinational steering logic of a five-stage in-order integer pipeline. For each of the two source registers of the instruction in the execute stage, it chooses the operand source. The source is the register-file read value, the result held in the EX/MEM pipeline register, or the result held in the MEM/WB pipeline register. It also chooses whether a store in the memory stage takes its write data from the MEM/WB result rather than from the value it carried down the pipeline. The register file, the ALU, the multiplexers and the pipeline registers belong to the surrounding datapath.

The second job is interlock. When a load in execute produces a register that the instruction in decode needs as an ALU operand, no bypass path can deliver the data in time. The block then holds the program counter and the IF/ID register for one cycle and turns the ID/EX entry into a bubble. The datapath clears that entry's register-write and memory-access controls. When the decode instruction is a store that needs the loaded register only as its write data, no interlock is raised. The value reaches the store in the memory stage through the store-data bypass instead.

The register file is assumed to write in the first half of a cycle and read in the second. A consumer three instructions behind its producer therefore reads the correct value directly and needs no bypass.

Top module: `fwdhaz_unit`

## Requirements
- R1: An ALU operand select is 2'b01 (EX/MEM result) when the EX/MEM producer has its write enable set, is not a load, and its nonzero destination equals that source register.
- R2: When R1 does not apply, an ALU operand select is 2'b10 (MEM/WB result) when the MEM/WB producer has its write enable set and its nonzero destination equals that source register.
- R3: When both EX/MEM and MEM/WB qualify for the same source, the select is 2'b01, because EX/MEM holds the younger result.
- R4: Register 0 is never bypassed and never causes an interlock, whatever the producers' destinations and enables.
- R5: A producer whose write enable is clear never causes a bypass or an interlock.
- R6: An EX/MEM producer that is a load is not used as a bypass source. The select falls back to MEM/WB or to the register file.
- R7: With no qualifying producer, an operand select is 2'b00 (register-file value). This covers a consumer three or more instructions behind its producer.
- R8: An interlock is raised when the ID/EX instruction is a load with its write enable set and a nonzero destination, and that destination equals the decode instruction's first source. It is also raised when the destination equals the second source and the decode instruction is not a store.
- R9: A decode-stage store whose second source (its write data) is the only match with a load in ID/EX raises no interlock.
- R10: The store-data select is 1 exactly when the EX/MEM instruction is a store and the MEM/WB producer has its write enable set, with a nonzero destination equal to the store's data register. Otherwise it is 0.
- R11: pc_hold, ifid_hold and idex_bubble are all 1 during an interlock and all 0 otherwise.
- R12: The two ALU operand selects are computed independently, each from its own source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_AW | First source register of the execute-stage instruction |
| ex_rt | input | REG_AW | Second source register of the execute-stage instruction |
| id_rs | input | REG_AW | First source register of the decode-stage instruction |
| id_rt | input | REG_AW | Second source register of the decode-stage instruction |
| id_is_store | input | 1 | Decode-stage instruction is a store |
| idex_rd | input | REG_AW | Destination held in ID/EX |
| idex_wen | input | 1 | Register-write enable held in ID/EX |
| idex_is_load | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | REG_AW | Destination held in EX/MEM |
| exmem_wen | input | 1 | Register-write enable held in EX/MEM |
| exmem_is_load | input | 1 | EX/MEM instruction is a load |
| exmem_is_store | input | 1 | EX/MEM instruction is a store |
| exmem_st_src | input | REG_AW | Data register of the store held in EX/MEM |
| memwb_rd | input | REG_AW | Destination held in MEM/WB |
| memwb_wen | input | 1 | Register-write enable held in MEM/WB |
| fwd_a_sel | output | 2 | First ALU operand source: 00 register file, 01 EX/MEM, 10 MEM/WB |
| fwd_b_sel | output | 2 | Second ALU operand source, same encoding |
| st_data_sel | output | 1 | 1: store write data taken from the MEM/WB result |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the IF/ID register |
| idex_bubble | output | 1 | Clear the write and memory controls entering ID/EX |

## Verification
The operand selects are swept over every combination of source register, producer destinations, write enables and EX/MEM load flag, using a four-register configuration. This separates the young-producer case, the old-producer case, the case where both producers match, the load in EX/MEM, and the register-zero case. The second operand is driven with a source that differs from the first, which shows that one select does not leak into the other. The interlock sweep covers both decode sources, the store flag and every ID/EX load/enable/destination pattern. This tells a real load-use hazard apart from a store that needs the loaded value only as write data. The store-data select is swept over every store flag, data register and MEM/WB producer.

// File: rtl/fwdhaz_pkg.sv
package fwdhaz_pkg;
    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_EXMEM = 2'b01,
        FWD_MEMWB = 2'b10
    } fwd_src_e;
endpackage

// File: rtl/fwd_src_sel.sv
module fwd_src_sel
    import fwdhaz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] exmem_rd,
    input  logic              exmem_wen,
    input  logic              exmem_is_load,
    input  logic [REG_AW-1:0] memwb_rd,
    input  logic              memwb_wen,
    output fwd_src_e          sel
);
    logic src_live;
    logic young_hit;
    logic old_hit;

    assign src_live  = (src != '0);
    assign young_hit = src_live && exmem_wen && !exmem_is_load && (exmem_rd == src);
    assign old_hit   = src_live && memwb_wen && (memwb_rd == src);

    always_comb begin
        unique case ({young_hit, old_hit})
            2'b10, 2'b11: sel = FWD_EXMEM;
            2'b01:        sel = FWD_MEMWB;
            default:      sel = FWD_RF;
        endcase
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_is_store,
    input  logic [REG_AW-1:0] idex_rd,
    input  logic              idex_wen,
    input  logic              idex_is_load,
    output logic              stall
);
    logic load_live;
    logic rs_hit;
    logic rt_hit;

    assign load_live = idex_is_load && idex_wen && (idex_rd != '0);
    assign rs_hit    = (id_rs == idex_rd);
    // a store's second source is write data, bypassed later in the memory stage
    assign rt_hit    = (id_rt == idex_rd) && !id_is_store;
    assign stall     = load_live && (rs_hit || rt_hit);
endmodule

// File: rtl/store_data_sel.sv
module store_data_sel #(
    parameter int REG_AW = 5
) (
    input  logic              exmem_is_store,
    input  logic [REG_AW-1:0] exmem_st_src,
    input  logic [REG_AW-1:0] memwb_rd,
    input  logic              memwb_wen,
    output logic              sel
);
    assign sel = exmem_is_store && memwb_wen && (memwb_rd != '0)
                 && (memwb_rd == exmem_st_src);
endmodule

// File: rtl/fwdhaz_unit.sv
module fwdhaz_unit
    import fwdhaz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_rs,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_is_store,
    input  logic [REG_AW-1:0] idex_rd,
    input  logic              idex_wen,
    input  logic              idex_is_load,
    input  logic [REG_AW-1:0] exmem_rd,
    input  logic              exmem_wen,
    input  logic              exmem_is_load,
    input  logic              exmem_is_store,
    input  logic [REG_AW-1:0] exmem_st_src,
    input  logic [REG_AW-1:0] memwb_rd,
    input  logic              memwb_wen,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              st_data_sel,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble
);
    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] op_src [NUM_OPS];
    fwd_src_e          op_sel [NUM_OPS];
    logic              stall;

    assign op_src[0] = ex_rs;
    assign op_src[1] = ex_rt;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_src_sel #(.REG_AW(REG_AW)) u_sel (
            .src           (op_src[g]),
            .exmem_rd      (exmem_rd),
            .exmem_wen     (exmem_wen),
            .exmem_is_load (exmem_is_load),
            .memwb_rd      (memwb_rd),
            .memwb_wen     (memwb_wen),
            .sel           (op_sel[g])
        );
    end

    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];

    load_use_detect #(.REG_AW(REG_AW)) u_lud (
        .id_rs        (id_rs),
        .id_rt        (id_rt),
        .id_is_store  (id_is_store),
        .idex_rd      (idex_rd),
        .idex_wen     (idex_wen),
        .idex_is_load (idex_is_load),
        .stall        (stall)
    );

    store_data_sel #(.REG_AW(REG_AW)) u_sds (
        .exmem_is_store (exmem_is_store),
        .exmem_st_src   (exmem_st_src),
        .memwb_rd       (memwb_rd),
        .memwb_wen      (memwb_wen),
        .sel            (st_data_sel)
    );

    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;
endmodule

// File: rtl/fwdhaz_unit_chk.sv
module fwdhaz_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] ex_rs,
    input logic [REG_AW-1:0] ex_rt,
    input logic [REG_AW-1:0] idex_rd,
    input logic              idex_wen,
    input logic              idex_is_load,
    input logic              exmem_wen,
    input logic              exmem_is_load,
    input logic              exmem_is_store,
    input logic              memwb_wen,
    input logic [1:0]        fwd_a_sel,
    input logic [1:0]        fwd_b_sel,
    input logic              st_data_sel,
    input logic              pc_hold,
    input logic              ifid_hold,
    input logic              idex_bubble
);
    always_comb begin
        AST_ZERO_SRC_A: assert (ex_rs != '0 || fwd_a_sel == 2'b00); // R4
        AST_ZERO_SRC_B: assert (ex_rt != '0 || fwd_b_sel == 2'b00); // R4
        AST_ZERO_NO_STALL: assert (idex_rd != '0 || !pc_hold); // R4
        AST_YOUNG_NEEDS_WRITER: assert (fwd_a_sel != 2'b01 || (exmem_wen && !exmem_is_load)); // R6
        AST_OLD_NEEDS_WRITER: assert (fwd_b_sel != 2'b10 || memwb_wen); // R5
        AST_SEL_LEGAL: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11); // R7
        AST_STALL_NEEDS_LOAD: assert (!pc_hold || (idex_is_load && idex_wen)); // R8
        AST_ST_NEEDS_STORE: assert (!st_data_sel || (exmem_is_store && memwb_wen)); // R10
        AST_FRONT_TOGETHER: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble); // R11
    end
endmodule

bind fwdhaz_unit fwdhaz_unit_chk #(.REG_AW(REG_AW)) u_chk (
    .ex_rs          (ex_rs),
    .ex_rt          (ex_rt),
    .idex_rd        (idex_rd),
    .idex_wen       (idex_wen),
    .idex_is_load   (idex_is_load),
    .exmem_wen      (exmem_wen),
    .exmem_is_load  (exmem_is_load),
    .exmem_is_store (exmem_is_store),
    .memwb_wen      (memwb_wen),
    .fwd_a_sel      (fwd_a_sel),
    .fwd_b_sel      (fwd_b_sel),
    .st_data_sel    (st_data_sel),
    .pc_hold        (pc_hold),
    .ifid_hold      (ifid_hold),
    .idex_bubble    (idex_bubble)
);

// File: tb/fwdhaz_unit_bench.sv
module fwdhaz_unit_bench;
    localparam int AW = 2;
    localparam int NR = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] ex_rs, ex_rt, id_rs, id_rt, idex_rd, exmem_rd, exmem_st_src, memwb_rd;
    logic id_is_store, idex_wen, idex_is_load, exmem_wen, exmem_is_load, exmem_is_store, memwb_wen;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic st_data_sel, pc_hold, ifid_hold, idex_bubble;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    fwdhaz_unit #(.REG_AW(AW)) u_fwdhaz_unit (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .id_rs(id_rs), .id_rt(id_rt),
        .id_is_store(id_is_store), .idex_rd(idex_rd), .idex_wen(idex_wen),
        .idex_is_load(idex_is_load), .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
        .exmem_is_load(exmem_is_load), .exmem_is_store(exmem_is_store),
        .exmem_st_src(exmem_st_src), .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .st_data_sel(st_data_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    function automatic logic [1:0] exp_sel(int src, int erd, bit ewen, bit eld, int mrd, bit mwen);
        if (src != 0 && ewen && !eld && erd == src) return 2'b01;  // R1 R3
        if (src != 0 && mwen && mrd == src) return 2'b10;           // R2 R6
        return 2'b00;                                              // R4 R5 R7
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        ex_rs = '0; ex_rt = '0; id_rs = '0; id_rt = '0; id_is_store = 1'b0;
        idex_rd = '0; idex_wen = 1'b0; idex_is_load = 1'b0;
        exmem_rd = '0; exmem_wen = 1'b0; exmem_is_load = 1'b0;
        exmem_is_store = 1'b0; exmem_st_src = '0; memwb_rd = '0; memwb_wen = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle_all();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // quiet state: all selects on register file, no interlock
        check("R7 idle a", {2'b0, fwd_a_sel}, 4'h0);
        check("R7 idle b", {2'b0, fwd_b_sel}, 4'h0);
        check("R11 idle front", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h0);
        check("R10 idle store", {3'b0, st_data_sel}, 4'h0);

        // operand bypass sweep, R1 R2 R3 R4 R5 R6 R7 R12
        for (int s = 0; s < NR; s++)
            for (int er = 0; er < NR; er++)
                for (int ew = 0; ew < 2; ew++)
                    for (int el = 0; el < 2; el++)
                        for (int mr = 0; mr < NR; mr++)
                            for (int mw = 0; mw < 2; mw++) begin
                                @(negedge clk);
                                ex_rs = AW'(s); ex_rt = AW'((s + 1) % NR);
                                exmem_rd = AW'(er); exmem_wen = ew[0]; exmem_is_load = el[0];
                                memwb_rd = AW'(mr); memwb_wen = mw[0];
                                #1;
                                check("R1/R2/R3 operand a", {2'b0, fwd_a_sel},
                                      {2'b0, exp_sel(s, er, ew[0], el[0], mr, mw[0])});
                                check("R12 operand b", {2'b0, fwd_b_sel},
                                      {2'b0, exp_sel((s + 1) % NR, er, ew[0], el[0], mr, mw[0])});
                            end
        idle_all();

        // interlock sweep, R4 R5 R8 R9 R11
        for (int a = 0; a < NR; a++)
            for (int b = 0; b < NR; b++)
                for (int st = 0; st < 2; st++)
                    for (int d = 0; d < NR; d++)
                        for (int w = 0; w < 2; w++)
                            for (int l = 0; l < 2; l++) begin
                                bit hz;
                                @(negedge clk);
                                id_rs = AW'(a); id_rt = AW'(b); id_is_store = st[0];
                                idex_rd = AW'(d); idex_wen = w[0]; idex_is_load = l[0];
                                #1;
                                hz = l[0] && w[0] && d != 0 && (a == d || (b == d && !st[0]));
                                check("R8/R9 interlock", {1'b0, pc_hold, ifid_hold, idex_bubble},
                                      {1'b0, hz, hz, hz});
                            end
        idle_all();

        // store-data bypass sweep, R10
        for (int st = 0; st < 2; st++)
            for (int sr = 0; sr < NR; sr++)
                for (int mr = 0; mr < NR; mr++)
                    for (int mw = 0; mw < 2; mw++) begin
                        bit e;
                        @(negedge clk);
                        exmem_is_store = st[0]; exmem_st_src = AW'(sr);
                        memwb_rd = AW'(mr); memwb_wen = mw[0];
                        #1;
                        e = st[0] && mw[0] && mr != 0 && mr == sr;
                        check("R10 store data", {3'b0, st_data_sel}, {3'b0, e});
                    end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule